// File: doc/BRIEF.md
# Burst Readback Verify Engine

This block confirms that a target's flash holds the intended image. It reads the image back word by word through a debug access port and compares each word with the expected copy held in a local page buffer. It drives the access port's control register, address register and data register through a single-request handshake. Before the burst starts it switches the control register to auto-increment. When the burst ends it switches auto-increment off again.

The target's address auto-increment only counts inside an aligned window, such as 1 KB or 4 KB, depending on the target family. The engine therefore rewrites the address register every time the next read address falls on a window boundary. It also loads the address register at the first word, even when that word does not sit on a boundary. The expected data arrives one external page at a time, so the engine asks the buffer for a new page whenever the read address enters one. Each read waits until the buffer reports valid data. On the first mismatch the engine stops. It keeps the failing address, the expected word and the word read until the next run starts.

Top module: `rbv_verify_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `ap_req` and `buf_fetch_req` are all 0.
- R2: A start with `word_count` of zero produces a one-cycle `done` on the next cycle with `pass` = 1, and makes no access-port or page-fetch request.
- R3: In a run with a nonzero count, the first access-port transfer writes the control register (`ap_sel` = 2'b00) with `CTRL_INC`. The last transfer writes it with `CTRL_OFF`, and `done` follows that transfer's acknowledge by one cycle. Every data read happens while auto-increment is on.
- R4: The address register (`ap_sel` = 2'b01) is written with `start_addr` before the first data read, even when `start_addr` is not on a wrap boundary. Addresses are byte addresses of 32-bit words.
- R5: After the first word, the address register is written again exactly when the next read address ANDed with `wrap_mask` is zero (`wrap_mask` is 0x3FF or 0xFFF), and at no other time.
- R6: A page fetch (`buf_fetch_req`, with `buf_fetch_addr` equal to the address rounded down to `PAGE_BYTES` = 64) is made for the first word and for every word whose address is a multiple of `PAGE_BYTES`.
- R7: A data read (`ap_sel` = 2'b11, `ap_wr` = 0) is issued only after `buf_word_valid` has been seen high for the current word. The expected word is taken from `buf_word` at that point.
- R8: On the first mismatch no further data read is issued. `pass` ends at 0, and `fail_addr`, `fail_exp` and `fail_got` hold the word's address, the expected word and the word read. Auto-increment is still switched off before `done`.
- R9: When every word matches, exactly `word_count` data reads are made and `pass` is 1 at `done`.
- R10: `ap_req` with its select, direction and write data, and `buf_fetch_req` with its address, stay stable until acknowledged, whatever the acknowledge latency.
- R11: `pass` and the failure fields hold after `done` until the next start. A new start clears `pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| start_addr | input | AW | Byte address of the first word |
| word_count | input | CNT_W | Number of words to verify |
| wrap_mask | input | AW | Auto-increment wrap window mask |
| ap_req | output | 1 | Access-port transfer request |
| ap_wr | output | 1 | 1 = register write, 0 = read |
| ap_sel | output | 2 | Register select: 00 control, 01 address, 11 data |
| ap_wdata | output | DW | Write data |
| ap_ack | input | 1 | Transfer complete; read data valid |
| ap_rdata | input | DW | Read data |
| buf_fetch_req | output | 1 | Request a page load into the buffer |
| buf_fetch_addr | output | AW | Page base address |
| buf_fetch_done | input | 1 | Page load complete |
| buf_word_addr | output | AW | Address of the expected word wanted |
| buf_word_valid | input | 1 | Expected word is valid |
| buf_word | input | DW | Expected word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Run verified with no mismatch |
| fail_addr | output | AW | Address of first mismatch |
| fail_exp | output | DW | Expected word at first mismatch |
| fail_got | output | DW | Word read at first mismatch |

## Verification
An aligned run of 40 words inside one 4 KB window shows the single address load and the page fetches at each 64-byte step. An unaligned start just below a 1 KB boundary is run once with the 1 KB mask and once with the 4 KB mask. The target model wraps its address inside the window, so a missing rewrite reads wrong data, and an extra rewrite shows in the transfer count. A corrupted expected word in the middle of a run shows that the engine stops and records the first mismatch. Withholding buffer valid shows that reads are gated, and slower acknowledges stress the request hold.

// File: rtl/rbv_pkg.sv
package rbv_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'b00,
      REG_ADDR = 2'b01,
      REG_DATA = 2'b11
   } ap_reg_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL_ON,
      ST_PAGE_CHK,
      ST_PAGE_LD,
      ST_ADDR_CHK,
      ST_ADDR_WR,
      ST_EXP_WAIT,
      ST_READ,
      ST_CTRL_OFF,
      ST_FINISH
   } seq_state_e;

endpackage

// File: rtl/rbv_addr_track.sv
module rbv_addr_track #(
   parameter int AW         = 32,
   parameter int CNT_W      = 16,
   parameter int PAGE_BYTES = 64,
   parameter int STEP_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [AW-1:0]    start_addr,
   input  logic [CNT_W-1:0] word_count,
   input  logic [AW-1:0]    wrap_mask,
   output logic [AW-1:0]    cur_addr,
   output logic             last_word,
   output logic             need_addr,
   output logic             need_page,
   output logic [AW-1:0]    page_base
);

   localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);
   localparam logic [AW-1:0] STEP      = AW'(STEP_BYTES);

   logic [CNT_W-1:0] remain;
   logic             first;

   if (PAGE_BYTES < STEP_BYTES || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("rbv_addr_track: PAGE_BYTES must be a power of two no smaller than a word");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rbv_addr_track: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         remain   <= '0;
         first    <= 1'b0;
      end else if (load) begin
         cur_addr <= start_addr;
         remain   <= word_count;
         first    <= 1'b1;
      end else if (step) begin
         cur_addr <= cur_addr + STEP;
         remain   <= remain - CNT_W'(1);
         first    <= 1'b0;
      end
   end

   assign last_word = (remain == CNT_W'(1));
   assign need_addr = first | ((cur_addr & wrap_mask) == '0);
   assign need_page = first | ((cur_addr & PAGE_MASK) == '0);
   assign page_base = cur_addr & ~PAGE_MASK;

endmodule

// File: rtl/rbv_compare.sv
module rbv_compare #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LANES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          exp_load,
   input  logic [DW-1:0] exp_in,
   input  logic          cmp_en,
   input  logic [DW-1:0] got,
   input  logic [AW-1:0] cur_addr,
   output logic          mismatch,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_got
);

   localparam int LW = DW / LANES;

   logic [DW-1:0]    exp_q;
   logic [LANES-1:0] lane_diff;

   if (LANES < 1 || (DW % LANES) != 0) begin : g_bad_lanes
      $error("rbv_compare: DW must split evenly into LANES");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_diff[g] = (exp_q[g*LW +: LW] != got[g*LW +: LW]);
   end

   assign mismatch = |lane_diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= '0;
      end else if (exp_load) begin
         exp_q <= exp_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_got  <= '0;
      end else if (clear) begin
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_got  <= '0;
      end else if (cmp_en && mismatch) begin
         fail_addr <= cur_addr;
         fail_exp  <= exp_q;
         fail_got  <= got;
      end
   end

endmodule

// File: rtl/rbv_sequencer.sv
module rbv_sequencer
   import rbv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       count_zero,
   input  logic       ap_ack,
   input  logic       fetch_done,
   input  logic       word_valid,
   input  logic       last_word,
   input  logic       need_addr,
   input  logic       need_page,
   input  logic       mismatch,
   output logic       ap_req,
   output logic       ap_wr,
   output logic [1:0] ap_sel,
   output logic       ctrl_on,
   output logic       fetch_req,
   output logic       trk_load,
   output logic       trk_step,
   output logic       exp_load,
   output logic       cmp_en,
   output logic       res_clear,
   output logic       done,
   output logic       busy,
   output logic       pass
);

   seq_state_e state_q, state_d;
   ap_reg_e    sel;

   always_comb begin
      state_d   = state_q;
      ap_req    = 1'b0;
      ap_wr     = 1'b0;
      sel       = REG_CTRL;
      ctrl_on   = 1'b0;
      fetch_req = 1'b0;
      trk_load  = 1'b0;
      trk_step  = 1'b0;
      exp_load  = 1'b0;
      cmp_en    = 1'b0;
      res_clear = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               trk_load  = 1'b1;
               res_clear = 1'b1;
               state_d   = count_zero ? ST_FINISH : ST_CTRL_ON;
            end
         end
         ST_CTRL_ON: begin
            ap_req  = 1'b1;
            ap_wr   = 1'b1;
            ctrl_on = 1'b1;
            if (ap_ack) state_d = ST_PAGE_CHK;
         end
         ST_PAGE_CHK: begin
            state_d = need_page ? ST_PAGE_LD : ST_ADDR_CHK;
         end
         ST_PAGE_LD: begin
            fetch_req = 1'b1;
            if (fetch_done) state_d = ST_ADDR_CHK;
         end
         ST_ADDR_CHK: begin
            state_d = need_addr ? ST_ADDR_WR : ST_EXP_WAIT;
         end
         ST_ADDR_WR: begin
            ap_req = 1'b1;
            ap_wr  = 1'b1;
            sel    = REG_ADDR;
            if (ap_ack) state_d = ST_EXP_WAIT;
         end
         ST_EXP_WAIT: begin
            if (word_valid) begin
               exp_load = 1'b1;
               state_d  = ST_READ;
            end
         end
         ST_READ: begin
            ap_req = 1'b1;
            sel    = REG_DATA;
            if (ap_ack) begin
               cmp_en = 1'b1;
               if (mismatch) begin
                  state_d = ST_CTRL_OFF;
               end else begin
                  trk_step = 1'b1;
                  state_d  = last_word ? ST_CTRL_OFF : ST_PAGE_CHK;
               end
            end
         end
         ST_CTRL_OFF: begin
            ap_req = 1'b1;
            ap_wr  = 1'b1;
            if (ap_ack) state_d = ST_FINISH;
         end
         ST_FINISH: begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass <= 1'b0;
      end else if (res_clear) begin
         pass <= count_zero;
      end else if (cmp_en && !mismatch && last_word) begin
         pass <= 1'b1;
      end
   end

   assign ap_sel = sel;
   assign done   = (state_q == ST_FINISH);
   assign busy   = (state_q != ST_IDLE) && (state_q != ST_FINISH);

endmodule

// File: rtl/rbv_verify_engine.sv
module rbv_verify_engine
   import rbv_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          DW         = 32,
   parameter int          CNT_W      = 16,
   parameter int          PAGE_BYTES = 64,
   parameter int          LANES      = 4,
   parameter logic [31:0] CTRL_INC   = 32'h0000_0012,
   parameter logic [31:0] CTRL_OFF   = 32'h0000_0002
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic [CNT_W-1:0] word_count,
   input  logic [AW-1:0]    wrap_mask,
   output logic             ap_req,
   output logic             ap_wr,
   output logic [1:0]       ap_sel,
   output logic [DW-1:0]    ap_wdata,
   input  logic             ap_ack,
   input  logic [DW-1:0]    ap_rdata,
   output logic             buf_fetch_req,
   output logic [AW-1:0]    buf_fetch_addr,
   input  logic             buf_fetch_done,
   output logic [AW-1:0]    buf_word_addr,
   input  logic             buf_word_valid,
   input  logic [DW-1:0]    buf_word,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic [AW-1:0]    fail_addr,
   output logic [DW-1:0]    fail_exp,
   output logic [DW-1:0]    fail_got
);

   localparam int STEP_BYTES = DW / 8;

   if (DW != 32) begin : g_bad_dw
      $error("rbv_verify_engine: data path must be 32 bits wide");
   end
   if (AW > DW || AW < 8) begin : g_bad_aw
      $error("rbv_verify_engine: AW must lie between 8 and DW");
   end

   logic          ctrl_on;
   logic          trk_load, trk_step, exp_load, cmp_en, res_clear;
   logic          last_word, need_addr, need_page, mismatch;
   logic [AW-1:0] cur_addr, page_base;
   logic          count_zero;

   assign count_zero = (word_count == '0);

   rbv_addr_track #(
      .AW         (AW),
      .CNT_W      (CNT_W),
      .PAGE_BYTES (PAGE_BYTES),
      .STEP_BYTES (STEP_BYTES)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (trk_load),
      .step       (trk_step),
      .start_addr (start_addr),
      .word_count (word_count),
      .wrap_mask  (wrap_mask),
      .cur_addr   (cur_addr),
      .last_word  (last_word),
      .need_addr  (need_addr),
      .need_page  (need_page),
      .page_base  (page_base)
   );

   rbv_compare #(
      .AW    (AW),
      .DW    (DW),
      .LANES (LANES)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (res_clear),
      .exp_load  (exp_load),
      .exp_in    (buf_word),
      .cmp_en    (cmp_en),
      .got       (ap_rdata),
      .cur_addr  (cur_addr),
      .mismatch  (mismatch),
      .fail_addr (fail_addr),
      .fail_exp  (fail_exp),
      .fail_got  (fail_got)
   );

   rbv_sequencer u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .count_zero (count_zero),
      .ap_ack     (ap_ack),
      .fetch_done (buf_fetch_done),
      .word_valid (buf_word_valid),
      .last_word  (last_word),
      .need_addr  (need_addr),
      .need_page  (need_page),
      .mismatch   (mismatch),
      .ap_req     (ap_req),
      .ap_wr      (ap_wr),
      .ap_sel     (ap_sel),
      .ctrl_on    (ctrl_on),
      .fetch_req  (buf_fetch_req),
      .trk_load   (trk_load),
      .trk_step   (trk_step),
      .exp_load   (exp_load),
      .cmp_en     (cmp_en),
      .res_clear  (res_clear),
      .done       (done),
      .busy       (busy),
      .pass       (pass)
   );

   always_comb begin
      if (!ap_wr) begin
         ap_wdata = '0;
      end else if (ap_sel == REG_ADDR) begin
         ap_wdata = DW'(cur_addr);
      end else if (ctrl_on) begin
         ap_wdata = DW'(CTRL_INC);
      end else begin
         ap_wdata = DW'(CTRL_OFF);
      end
   end

   assign buf_fetch_addr = page_base;
   assign buf_word_addr  = cur_addr;

endmodule

// File: rtl/rbv_verify_sva.sv
module rbv_verify_sva #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          ap_req,
   input logic          ap_wr,
   input logic [1:0]    ap_sel,
   input logic [DW-1:0] ap_wdata,
   input logic          ap_ack,
   input logic          buf_fetch_req,
   input logic [AW-1:0] buf_fetch_addr,
   input logic          buf_fetch_done,
   input logic          buf_word_valid,
   input logic          busy,
   input logic          done,
   input logic          pass,
   input logic [AW-1:0] fail_addr
);

   logic data_rd;
   assign data_rd = ap_req && !ap_wr && (ap_sel == 2'b11);

   assert_ap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ap_req && !ap_ack |=> ap_req && $stable(ap_sel) && $stable(ap_wr) && $stable(ap_wdata));

   assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      buf_fetch_req && !buf_fetch_done |=> buf_fetch_req && $stable(buf_fetch_addr));

   assert_read_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_rd) |-> $past(buf_word_valid));

   assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ap_req && buf_fetch_req));

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !ap_req && !buf_fetch_req);

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(pass) && $stable(fail_addr));

endmodule

bind rbv_verify_engine rbv_verify_sva #(
   .AW (AW),
   .DW (DW)
) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .start          (start),
   .ap_req         (ap_req),
   .ap_wr          (ap_wr),
   .ap_sel         (ap_sel),
   .ap_wdata       (ap_wdata),
   .ap_ack         (ap_ack),
   .buf_fetch_req  (buf_fetch_req),
   .buf_fetch_addr (buf_fetch_addr),
   .buf_fetch_done (buf_fetch_done),
   .buf_word_valid (buf_word_valid),
   .busy           (busy),
   .done           (done),
   .pass           (pass),
   .fail_addr      (fail_addr)
);

// File: tb/tb_rbv_verify_engine.sv
`timescale 1ns/1ps
module tb_rbv_verify_engine;

   localparam logic [31:0] C_INC = 32'h0000_0012;
   localparam logic [31:0] C_OFF = 32'h0000_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic [15:0] word_count = '0;
   logic [31:0] wrap_mask = 32'hFFF;
   logic        ap_req, ap_wr;
   logic [1:0]  ap_sel;
   logic [31:0] ap_wdata;
   logic        ap_ack = 1'b0;
   logic [31:0] ap_rdata = '0;
   logic        buf_fetch_req;
   logic [31:0] buf_fetch_addr;
   logic        buf_fetch_done = 1'b0;
   logic [31:0] buf_word_addr;
   logic        buf_word_valid;
   logic [31:0] buf_word;
   logic        busy, done, pass;
   logic [31:0] fail_addr, fail_exp, fail_got;

   always #2 clk = ~clk;

   rbv_verify_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .wrap_mask(wrap_mask),
      .ap_req(ap_req), .ap_wr(ap_wr), .ap_sel(ap_sel), .ap_wdata(ap_wdata),
      .ap_ack(ap_ack), .ap_rdata(ap_rdata),
      .buf_fetch_req(buf_fetch_req), .buf_fetch_addr(buf_fetch_addr),
      .buf_fetch_done(buf_fetch_done), .buf_word_addr(buf_word_addr),
      .buf_word_valid(buf_word_valid), .buf_word(buf_word),
      .busy(busy), .done(done), .pass(pass),
      .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
   );

   int n_checks = 0;
   int n_fails  = 0;

   // target and buffer models
   int          ap_delay = 0;
   int          fetch_delay = 1;
   bit          stall = 1'b0;
   bit          bad_en = 1'b0;
   logic [31:0] bad_addr = '0;
   logic [31:0] tar = '0;
   logic [31:0] ctrl_q = '0;
   int          n_tx = 0, n_reads = 0, n_noinc = 0, n_fetch = 0;
   logic [1:0]  log_sel [256];
   logic        log_wr  [256];
   logic [31:0] log_dat [256];
   logic [31:0] flog    [16];
   int          wcnt = 0, fcnt = 0;

   function automatic logic [31:0] tgt_word(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   assign buf_word = tgt_word(buf_word_addr) ^
                     ((bad_en && buf_word_addr == bad_addr) ? 32'h0000_0100 : 32'h0);
   assign buf_word_valid = !stall;

   always @(posedge clk) begin
      if (!rst_n) begin
         ap_ack <= 1'b0;
         wcnt   <= 0;
      end else if (ap_ack) begin
         ap_ack <= 1'b0;
         wcnt   <= 0;
         log_sel[n_tx & 255] <= ap_sel;
         log_wr[n_tx & 255]  <= ap_wr;
         log_dat[n_tx & 255] <= ap_wr ? ap_wdata : ap_rdata;
         n_tx <= n_tx + 1;
         if (ap_wr) begin
            if (ap_sel == 2'b00) ctrl_q <= ap_wdata;
            else if (ap_sel == 2'b01) tar <= ap_wdata;
         end else begin
            n_reads <= n_reads + 1;
            if (ctrl_q != C_INC) n_noinc <= n_noinc + 1;
            tar <= (tar & ~wrap_mask) | ((tar + 32'd4) & wrap_mask);
         end
      end else if (ap_req) begin
         if (wcnt >= ap_delay) begin
            ap_ack   <= 1'b1;
            ap_rdata <= tgt_word(tar);
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         buf_fetch_done <= 1'b0;
         fcnt <= 0;
      end else if (buf_fetch_done) begin
         buf_fetch_done <= 1'b0;
         fcnt <= 0;
         flog[n_fetch & 15] <= buf_fetch_addr;
         n_fetch <= n_fetch + 1;
      end else if (buf_fetch_req) begin
         if (fcnt >= fetch_delay) buf_fetch_done <= 1'b1;
         else fcnt <= fcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [31:0] a, input logic [15:0] n, input logic [31:0] m);
      @(negedge clk);
      start_addr = a;
      word_count = n;
      wrap_mask  = m;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      bit seen = 1'b0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
      chk(seen, tag, 32'(seen), 32'd1);
      @(negedge clk);
   endtask

   // counts the address-register writes inside a window of the log
   function automatic int addr_writes(input int from, input int to);
      int c = 0;
      for (int i = from; i < to; i++)
         if (log_wr[i & 255] && log_sel[i & 255] == 2'b01) c++;
      return c;
   endfunction

   task automatic t_reset;
      chk(!busy && !done && !pass, "R1 status idle", {29'd0, busy, done, pass}, 32'd0);
      chk(!ap_req && !buf_fetch_req, "R1 no requests", {30'd0, ap_req, buf_fetch_req}, 32'd0);
   endtask

   task automatic t_zero;
      int tx0 = n_tx;
      int f0 = n_fetch;
      launch(32'h0000_0100, 16'd0, 32'hFFF);
      // start accepted at the first edge, done is visible now
      chk(done && pass, "R2 immediate done", {30'd0, done, pass}, 32'd3);
      repeat (3) @(negedge clk);
      chk(n_tx == tx0 && n_fetch == f0, "R2 no traffic", 32'(n_tx - tx0 + n_fetch - f0), 32'd0);
   endtask

   task automatic t_aligned;
      int tx0 = n_tx, r0 = n_reads, f0 = n_fetch, ni0 = n_noinc;
      ap_delay = 0;
      launch(32'h0000_1000, 16'd40, 32'hFFF);
      wait_done("R9 aligned run done");
      chk(pass, "R9 aligned pass", 32'(pass), 32'd1);
      chk(n_reads - r0 == 40, "R9 read count", 32'(n_reads - r0), 32'd40);
      chk(log_wr[tx0 & 255] && log_sel[tx0 & 255] == 2'b00 && log_dat[tx0 & 255] == C_INC,
          "R3 first control write", log_dat[tx0 & 255], C_INC);
      chk(log_wr[(n_tx - 1) & 255] && log_sel[(n_tx - 1) & 255] == 2'b00 &&
          log_dat[(n_tx - 1) & 255] == C_OFF, "R3 last control write",
          log_dat[(n_tx - 1) & 255], C_OFF);
      chk(n_noinc == ni0, "R3 reads under auto-increment", 32'(n_noinc - ni0), 32'd0);
      chk(log_sel[(tx0 + 1) & 255] == 2'b01 && log_dat[(tx0 + 1) & 255] == 32'h1000,
          "R4 start address load", log_dat[(tx0 + 1) & 255], 32'h1000);
      chk(addr_writes(tx0, n_tx) == 1, "R5 no extra address writes",
          32'(addr_writes(tx0, n_tx)), 32'd1);
      chk(n_fetch - f0 == 3, "R6 page fetch count", 32'(n_fetch - f0), 32'd3);
      for (int k = 0; k < 3; k++)
         chk(flog[(f0 + k) & 15] == 32'h1000 + 32'(k * 64), "R6 page fetch address",
             flog[(f0 + k) & 15], 32'h1000 + 32'(k * 64));
   endtask

   task automatic t_wrap_small;
      int tx0 = n_tx, f0 = n_fetch;
      int idx = 0;
      logic [31:0] seen [2];
      ap_delay = 2;
      launch(32'h0000_03F8, 16'd6, 32'h3FF);
      wait_done("R5 wrap run done");
      chk(pass, "R5 wrap run pass", 32'(pass), 32'd1);
      chk(addr_writes(tx0, n_tx) == 2, "R5 rewrite at 1K boundary",
          32'(addr_writes(tx0, n_tx)), 32'd2);
      seen[0] = '0;
      seen[1] = '0;
      for (int i = tx0; i < n_tx; i++)
         if (log_wr[i & 255] && log_sel[i & 255] == 2'b01 && idx < 2) begin
            seen[idx] = log_dat[i & 255];
            idx++;
         end
      chk(seen[0] == 32'h3F8, "R4 unaligned start load", seen[0], 32'h3F8);
      chk(seen[1] == 32'h400, "R5 boundary address", seen[1], 32'h400);
      chk(n_fetch - f0 == 2 && flog[f0 & 15] == 32'h3C0 && flog[(f0 + 1) & 15] == 32'h400,
          "R6 unaligned page fetches", flog[(f0 + 1) & 15], 32'h400);
   endtask

   task automatic t_wrap_wide;
      int tx0 = n_tx;
      ap_delay = 1;
      launch(32'h0000_03F8, 16'd6, 32'hFFF);
      wait_done("R5 wide window done");
      chk(pass, "R5 wide window pass", 32'(pass), 32'd1);
      chk(addr_writes(tx0, n_tx) == 1, "R5 no rewrite inside 4K",
          32'(addr_writes(tx0, n_tx)), 32'd1);
   endtask

   task automatic t_mismatch;
      int tx0 = n_tx, r0 = n_reads;
      ap_delay = 0;
      bad_en   = 1'b1;
      bad_addr = 32'h0000_200C;
      launch(32'h0000_2000, 16'd10, 32'hFFF);
      wait_done("R8 mismatch run done");
      chk(!pass, "R8 pass low", 32'(pass), 32'd0);
      chk(n_reads - r0 == 4, "R8 reads stop at mismatch", 32'(n_reads - r0), 32'd4);
      chk(fail_addr == 32'h200C, "R8 fail address", fail_addr, 32'h200C);
      chk(fail_exp == (tgt_word(32'h200C) ^ 32'h100), "R8 fail expected", fail_exp,
          tgt_word(32'h200C) ^ 32'h100);
      chk(fail_got == tgt_word(32'h200C), "R8 fail read", fail_got, tgt_word(32'h200C));
      chk(log_dat[(n_tx - 1) & 255] == C_OFF && log_wr[(n_tx - 1) & 255],
          "R8 auto-increment off", log_dat[(n_tx - 1) & 255], C_OFF);
      chk(addr_writes(tx0, n_tx) == 1, "R8 single address load",
          32'(addr_writes(tx0, n_tx)), 32'd1);
      bad_en = 1'b0;
   endtask

   task automatic t_hold;
      repeat (12) @(negedge clk);
      chk(fail_addr == 32'h200C && !pass, "R11 result held", fail_addr, 32'h200C);
      launch(32'h0000_2000, 16'd3, 32'hFFF);
      chk(!pass && busy, "R11 start clears pass", {30'd0, pass, busy}, 32'd1);
      wait_done("R11 rerun done");
      chk(pass, "R11 rerun pass", 32'(pass), 32'd1);
   endtask

   task automatic t_stall;
      int r0 = n_reads;
      stall = 1'b1;
      launch(32'h0000_3000, 16'd4, 32'hFFF);
      repeat (30) @(negedge clk);
      chk(n_reads == r0 && busy, "R7 no read while buffer invalid", 32'(n_reads - r0), 32'd0);
      stall = 1'b0;
      wait_done("R7 stalled run done");
      chk(pass && n_reads - r0 == 4, "R7 reads after valid", 32'(n_reads - r0), 32'd4);
   endtask

   task automatic t_slow_ack;
      int r0 = n_reads;
      ap_delay    = 4;
      fetch_delay = 3;
      launch(32'h0000_0FF0, 16'd12, 32'h3FF);
      wait_done("R10 slow acknowledge done");
      chk(pass && n_reads - r0 == 12, "R10 slow acknowledge pass", 32'(n_reads - r0), 32'd12);
      ap_delay    = 0;
      fetch_delay = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_zero();
      t_aligned();
      t_wrap_small();
      t_wrap_wide();
      t_mismatch();
      t_hold();
      t_stall();
      t_slow_ack();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule